// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the programming state of an I/O interrupt router: a four-bit controller identity and one 64-bit routing entry for each interrupt pin. Software reaches all of it through two words on a small memory-mapped bus. The first word is a select register that names an internal register. The second word is a data window that reads or writes the named register. The internal registers are the identity, a read-only version word, a read-only arbitration word, and two 32-bit halves of each routing entry.

Each routing entry and the identity go out on flat ports to the pin logic. The pin logic can set the in-flight (remote request) status bit of any entry through a per-pin strobe. When a window write changes the mask bit of an entry, the block sends a one-cycle mask-change event one clock later. The event carries the pin number and the new mask value.

The bus request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each read that is taken returns exactly one response on a valid/ready response channel. A write returns no response. The block holds one response. While that response waits with `rsp_ready` low, `req_ready` is low, so a new request cannot overwrite it.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, every entry reads as low half 0x00010000 (only the mask bit, bit 16, is set) and high half 0. The select register and the identity are 0. No response is pending.
- R2: A write to address offset 0x00 stores wdata[7:0] in the select register. A read of offset 0x00 returns the select value, zero-extended to 32 bits.
- R3: With select 0x01, a window (offset 0x10) read returns (pin count − 1) in bits 23:16 and the version code 0x11 in bits 7:0, giving 0x00170011 for 24 pins. Window writes to this register change nothing.
- R4: With select 0x00, a window write stores wdata[27:24] as the identity, which then drives `apic_id`. A read returns the identity in bits 27:24 and zeros elsewhere. With select 0x02, a window read returns the same word and a window write changes nothing.
- R5: A select value s ≥ 0x10 addresses entry (s − 0x10) >> 1. An even s reaches bits 31:0 and an odd s reaches bits 63:32. Written data reads back unchanged and appears on `tbl_flat[64*p +: 64]`.
- R6: A write to a low half stores wdata, except that bit 14 (remote request) is forced to 0. A write to a high half leaves bit 14 unchanged.
- R7: A pulse on `rirr_set[p]` sets bit 14 of entry p at the next edge. If a low-half write to the same entry is taken on that edge, the write wins and bit 14 ends at 0.
- R8: A window write whose entry index is 24 or more, or whose select value is 0x03 to 0x0F, changes no state. Window reads of these select values return 0.
- R9: A low-half write that changes bit 16 of entry p makes `mask_evt_valid` high for exactly one cycle, right after the write edge, with `mask_evt_pin` = p and `mask_evt_masked` = new bit 16. A write that leaves the mask unchanged, and any high-half write, raise no event.
- R10: A response that is not accepted keeps `rsp_valid` high and `rsp_rdata` stable. `req_ready` stays low until `rsp_ready` is high. Writes produce no response.
- R11: Only address bits 7:0 are decoded. Low-byte offsets other than 0x00 and 0x10 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request can be taken |
| req_addr | input | 32 | Byte address; only bits 7:0 are decoded |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_rdata | output | 32 | Read data |
| rirr_set | input | 24 | Per-pin strobe that sets the remote request bit |
| tbl_flat | output | 1536 | All routing entries; entry p at bits 64*p+63 : 64*p |
| apic_id | output | 4 | Controller identity |
| mask_evt_valid | output | 1 | Mask-change event strobe |
| mask_evt_pin | output | 5 | Pin whose mask changed |
| mask_evt_masked | output | 1 | New mask value |

## Verification
The hardest case to reach is a low-half write and a remote-request set on the same entry at the same edge. The bus write has to land exactly on the edge where the pin-side strobe is high. The bench drives both at the same falling edge, so the write is taken and the strobe is sampled together. A second hard case is a response held under back-pressure. The bench lowers `rsp_ready` before a read and then checks across several cycles that `req_ready` stays low and the data does not move. Mask events are caught right after the write edge, both for writes that change the mask and for writes that do not.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;
  localparam int BIT_RIRR = 14;
  localparam int BIT_MASK = 16;
  localparam logic [31:0] ENT_RST_LO = 32'h0001_0000;

  typedef enum logic [2:0] {
    RD_ZERO, RD_SEL, RD_ID, RD_VER, RD_LO, RD_HI
  } rd_src_e;
endpackage

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  output logic [63:0] ent,
  output logic        mask_flip
);
  localparam logic [31:0] LO_KEEP = ~(32'h1 << BIT_RIRR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent <= {32'h0, ENT_RST_LO};
    end else begin
      if (wr_hi) ent[63:32] <= wdata;
      if (wr_lo) ent[31:0] <= wdata & LO_KEEP;
      else if (rirr_set) ent[BIT_RIRR] <= 1'b1;
    end
  end

  assign mask_flip = wr_lo && (wdata[BIT_MASK] != ent[BIT_MASK]);
endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int NPINS = 24,
  parameter logic [7:0] VER_ID = 8'h11
) (
  input  logic [7:0]          off,
  input  logic [7:0]          sel,
  input  logic                wr,
  input  logic [3:0]          id,
  input  logic [NPINS*64-1:0] tbl,
  output logic                sel_wr,
  output logic                id_wr,
  output logic [NPINS-1:0]    lo_wr,
  output logic [NPINS-1:0]    hi_wr,
  output logic [31:0]         rd_word
);
  localparam logic [7:0] NPM1 = 8'(NPINS - 1);
  localparam logic [31:0] VER_WORD = {8'h00, NPM1, 8'h00, VER_ID};

  logic       win, in_tbl, idx_ok;
  logic [7:0] rel;
  logic [6:0] idx;
  logic [63:0] picked;
  rd_src_e    src;

  assign win    = (off == OFF_WIN);
  assign rel    = sel - SEL_TBL;
  assign idx    = rel[7:1];
  assign in_tbl = (sel >= SEL_TBL);

  always_comb begin
    idx_ok = 1'b0;
    picked = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (idx == 7'(i)) begin
        idx_ok = 1'b1;
        picked = tbl[i*64 +: 64];
      end
    end
  end

  assign sel_wr = wr && (off == OFF_SEL);
  assign id_wr  = wr && win && (sel == SEL_ID);

  for (genvar g = 0; g < NPINS; g++) begin : g_wr
    assign lo_wr[g] = wr && win && in_tbl && (idx == 7'(g)) && !sel[0];
    assign hi_wr[g] = wr && win && in_tbl && (idx == 7'(g)) &&  sel[0];
  end

  always_comb begin
    src = RD_ZERO;
    if (off == OFF_SEL) src = RD_SEL;
    else if (win) begin
      if (sel == SEL_ID || sel == SEL_ARB) src = RD_ID;
      else if (sel == SEL_VER) src = RD_VER;
      else if (in_tbl && idx_ok) src = sel[0] ? RD_HI : RD_LO;
    end
  end

  always_comb begin
    unique case (src)
      RD_SEL:  rd_word = {24'h0, sel};
      RD_ID:   rd_word = {4'h0, id, 24'h0};
      RD_VER:  rd_word = VER_WORD;
      RD_LO:   rd_word = picked[31:0];
      RD_HI:   rd_word = picked[63:32];
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/irq_route_rsp.sv
module irq_route_rsp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] ld_data,
  input  logic        rsp_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= ld_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int ADDR_W = 32,
  parameter logic [7:0] VER_ID = 8'h11,
  localparam int IDXW = $clog2(NPINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_we,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [31:0]         rsp_rdata,
  input  logic [NPINS-1:0]    rirr_set,
  output logic [NPINS*64-1:0] tbl_flat,
  output logic [3:0]          apic_id,
  output logic                mask_evt_valid,
  output logic [IDXW-1:0]     mask_evt_pin,
  output logic                mask_evt_masked
);
  logic             take, wr, sel_wr, id_wr;
  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  logic [NPINS-1:0] lo_wr, hi_wr, flip;
  logic [31:0]      rd_word;
  logic [IDXW-1:0]  flip_pin;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign wr        = take && req_we;

  irq_route_decode #(.NPINS(NPINS), .VER_ID(VER_ID)) u_dec (
    .off(req_addr[7:0]), .sel(sel_q), .wr(wr), .id(id_q), .tbl(tbl_flat),
    .sel_wr(sel_wr), .id_wr(id_wr), .lo_wr(lo_wr), .hi_wr(hi_wr),
    .rd_word(rd_word)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    irq_route_entry u_ent (
      .clk(clk), .rst_n(rst_n), .wr_lo(lo_wr[g]), .wr_hi(hi_wr[g]),
      .wdata(req_wdata), .rirr_set(rirr_set[g]),
      .ent(tbl_flat[g*64 +: 64]), .mask_flip(flip[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= req_wdata[7:0];
      if (id_wr)  id_q  <= req_wdata[27:24];
    end
  end
  assign apic_id = id_q;

  always_comb begin
    flip_pin = '0;
    for (int i = 0; i < NPINS; i++)
      if (flip[i]) flip_pin = IDXW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_evt_valid  <= 1'b0;
      mask_evt_pin    <= '0;
      mask_evt_masked <= 1'b0;
    end else begin
      mask_evt_valid <= |flip;
      if (|flip) begin
        mask_evt_pin    <= flip_pin;
        mask_evt_masked <= req_wdata[BIT_MASK];
      end
    end
  end

  irq_route_rsp u_rsp (
    .clk(clk), .rst_n(rst_n), .load(take && !req_we), .ld_data(rd_word),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int NPINS = 24,
  parameter int IDXW = 5,
  parameter int ADDR_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                req_we,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [31:0]         rsp_rdata,
  input logic [NPINS-1:0]    rirr_set,
  input logic [NPINS*64-1:0] tbl_flat,
  input logic [3:0]          apic_id,
  input logic                mask_evt_valid,
  input logic [IDXW-1:0]     mask_evt_pin,
  input logic                mask_evt_masked
);
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  assert_no_take_while_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_evt_matches_table_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt_valid |-> tbl_flat[mask_evt_pin*64 + 16] == mask_evt_masked);

  assert_id_by_window_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(apic_id) |-> $past(req_valid && req_ready && req_we && req_addr[7:0] == 8'h10));

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assert_rirr_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tbl_flat[g*64 + 14]) |-> $past(rirr_set[g]));
    assert_mask_change_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tbl_flat[g*64 + 16]) |-> mask_evt_valid && mask_evt_pin == IDXW'(g));
  end
endmodule

bind irq_route_regs irq_route_regs_chk #(.NPINS(NPINS), .IDXW(IDXW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_we(req_we), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rirr_set(rirr_set),
  .tbl_flat(tbl_flat), .apic_id(apic_id), .mask_evt_valid(mask_evt_valid),
  .mask_evt_pin(mask_evt_pin), .mask_evt_masked(mask_evt_masked)
);

// File: tb/irq_route_regs_bench.sv
module irq_route_regs_bench;
  localparam int PERIOD = 10;
  localparam int NPINS = 24;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h00, 32'h0, 32'h0, 8'd2},               // R2 select reset value
    '{1'b1, 32'h00, 32'h01, 32'h0, 8'd3},
    '{1'b0, 32'h10, 32'h0, 32'h00170011, 8'd3},        // R3 version
    '{1'b1, 32'h10, 32'hFFFFFFFF, 32'h0, 8'd3},
    '{1'b0, 32'h10, 32'h0, 32'h00170011, 8'd3},        // R3 write ignored
    '{1'b1, 32'h00, 32'h00, 32'h0, 8'd4},
    '{1'b1, 32'h10, 32'hA5000000, 32'h0, 8'd4},
    '{1'b0, 32'h10, 32'h0, 32'h05000000, 8'd4},        // R4 id
    '{1'b1, 32'h00, 32'h02, 32'h0, 8'd4},
    '{1'b0, 32'h10, 32'h0, 32'h05000000, 8'd4},        // R4 arbitration mirror
    '{1'b1, 32'h10, 32'h0F000000, 32'h0, 8'd4},
    '{1'b0, 32'h10, 32'h0, 32'h05000000, 8'd4},        // R4 arb write ignored
    '{1'b1, 32'h00, 32'h10, 32'h0, 8'd1},
    '{1'b0, 32'h10, 32'h0, 32'h00010000, 8'd1},        // R1 entry0 low
    '{1'b1, 32'h00, 32'h11, 32'h0, 8'd5},
    '{1'b0, 32'h10, 32'h0, 32'h0, 8'd1},               // R1 entry0 high
    '{1'b1, 32'h10, 32'hDE000000, 32'h0, 8'd5},
    '{1'b0, 32'h10, 32'h0, 32'hDE000000, 8'd5},        // R5 high half
    '{1'b1, 32'h00, 32'h10, 32'h0, 8'd6},
    '{1'b1, 32'h10, 32'h0001E731, 32'h0, 8'd6},
    '{1'b0, 32'h10, 32'h0, 32'h0001A731, 8'd6},        // R6 bit 14 forced
    '{1'b1, 32'h00, 32'h3F, 32'h0, 8'd5},
    '{1'b1, 32'h10, 32'h12345678, 32'h0, 8'd5},
    '{1'b0, 32'h10, 32'h0, 32'h12345678, 8'd5},        // R5 last entry high
    '{1'b1, 32'h00, 32'h3E, 32'h0, 8'd5},
    '{1'b0, 32'h10, 32'h0, 32'h00010000, 8'd5},        // R5 last entry low
    '{1'b1, 32'h00, 32'h40, 32'h0, 8'd8},
    '{1'b1, 32'h10, 32'hFFFFFFFF, 32'h0, 8'd8},
    '{1'b0, 32'h10, 32'h0, 32'h0, 8'd8},               // R8 index 24
    '{1'b1, 32'h00, 32'h05, 32'h0, 8'd8},
    '{1'b0, 32'h10, 32'h0, 32'h0, 8'd8},               // R8 hole select
    '{1'b0, 32'h04, 32'h0, 32'h0, 8'd11},              // R11 unused offset
    '{1'b1, 32'h20, 32'hFF, 32'h0, 8'd11},
    '{1'b0, 32'h20, 32'h0, 32'h0, 8'd11},              // R11
    '{1'b0, 32'h00, 32'h0, 32'h05, 8'd11},             // R11 select untouched
    '{1'b1, 32'h100, 32'h07, 32'h0, 8'd11},
    '{1'b0, 32'h00, 32'h0, 32'h07, 8'd11},             // R11 alias
    '{1'b1, 32'h00, 32'hABCDEF3E, 32'h0, 8'd2},
    '{1'b0, 32'h00, 32'h0, 32'h3E, 8'd2},              // R2 zero-extend
    '{1'b0, 32'h310, 32'h0, 32'h00010000, 8'd11}       // R11 window alias
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [31:0]         req_addr = '0, req_wdata = '0;
  logic                req_ready, rsp_valid;
  logic [31:0]         rsp_rdata;
  logic [NPINS-1:0]    rirr_set = '0;
  logic [NPINS*64-1:0] tbl_flat;
  logic [3:0]          apic_id;
  logic                mask_evt_valid, mask_evt_masked;
  logic [4:0]          mask_evt_pin;

  int n_cmp = 0, n_bad = 0;
  logic ev_v, ev_m;
  logic [4:0] ev_p;
  logic [31:0] rd;

  always #(PERIOD/2) clk = ~clk;

  irq_route_regs u_irq_route_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rirr_set(rirr_set), .tbl_flat(tbl_flat), .apic_id(apic_id),
    .mask_evt_valid(mask_evt_valid), .mask_evt_pin(mask_evt_pin),
    .mask_evt_masked(mask_evt_masked)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    ev_v = mask_evt_valid; ev_p = mask_evt_pin; ev_m = mask_evt_masked;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    begin : reset_checks
      logic all_ok;
      all_ok = 1'b1;
      for (int p = 0; p < NPINS; p++)
        if (tbl_flat[p*64 +: 64] !== 64'h0000_0000_0001_0000) all_ok = 1'b0;
      chk("R1 table reset", all_ok, 1'b1);
      chk("R1 id reset", apic_id, 4'h0);
      chk("R1 no response", rsp_valid, 1'b0);
    end

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].we) bus_write(VEC[v].addr, VEC[v].data);
      else begin
        bus_read(VEC[v].addr, rd);
        chk($sformatf("R%0d vector %0d", VEC[v].req, v), rd, VEC[v].exp);
      end
    end
    chk("R4 apic_id port", apic_id, 4'h5);
    chk("R8 entry 23 intact", tbl_flat[23*64 +: 64], 64'h12345678_00010000);
    chk("R6 entry 0 on port", tbl_flat[63:0], 64'hDE000000_0001A731);

    // R7: remote request set, high write keeps, low write clears
    rirr_set[3] = 1'b1; @(negedge clk); rirr_set[3] = 1'b0;
    chk("R7 set", tbl_flat[3*64 + 14], 1'b1);
    bus_write(32'h00, 32'h16);
    bus_read(32'h10, rd);
    chk("R7 window shows bit 14", rd, 32'h00014000);
    bus_write(32'h00, 32'h17);
    bus_write(32'h10, 32'hAB000000);
    chk("R6 high write keeps bit 14", tbl_flat[3*64 + 14], 1'b1);
    bus_write(32'h00, 32'h16);
    bus_write(32'h10, 32'h00010033);
    chk("R6 low write clears bit 14", tbl_flat[3*64 +: 64], 64'hAB000000_00010033);
    rirr_set[3] = 1'b1;
    bus_write(32'h10, 32'h00014044);
    rirr_set[3] = 1'b0;
    chk("R7 write wins over set", tbl_flat[3*64 +: 32], 32'h00010044);

    // R9: mask events on entry 5
    bus_write(32'h00, 32'h1A);
    chk("R9 no event on select write", ev_v, 1'b0);
    bus_write(32'h10, 32'h00000021);
    chk("R9 unmask event", {ev_v, ev_p, ev_m}, {1'b1, 5'd5, 1'b0});
    @(negedge clk);
    chk("R9 single cycle", mask_evt_valid, 1'b0);
    bus_write(32'h10, 32'h00000022);
    chk("R9 no event unchanged", ev_v, 1'b0);
    bus_write(32'h00, 32'h1B);
    bus_write(32'h10, 32'hFFFFFFFF);
    chk("R9 no event high write", ev_v, 1'b0);
    bus_write(32'h00, 32'h1A);
    bus_write(32'h10, 32'h00010022);
    chk("R9 mask event", {ev_v, ev_p, ev_m}, {1'b1, 5'd5, 1'b1});

    // R10: back-pressure on read response
    chk("R10 write gives no response", rsp_valid, 1'b0);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_we = 1'b0; req_addr = 32'h00;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R10 response up", {rsp_valid, rsp_rdata}, {1'b1, 32'h1A});
    chk("R10 ready low", req_ready, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 held", {rsp_valid, rsp_rdata, req_ready}, {1'b1, 32'h1A, 1'b0});
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", {rsp_valid, req_ready}, {1'b0, 1'b1});

    report();
  end
endmodule